// File: doc/BRIEF.md
# Two-Step Transmit Timestamp Queue

This block collects egress timestamps for frames that need a two-step time-sync follow-up. Software then pairs each timestamp with the frame it belongs to. When the egress path reports a stamped frame, the block appends two entries in one cycle. The first entry carries the transmit flag, the egress port, the nanosecond stamp and the sub-nanosecond bits. The second entry has the transmit flag clear and the same port. It carries the 9-bit frame identifier that travelled with the frame from ingress, split so that the upper identifier bits sit in the stamp field and the low 8 bits sit in the sub-nanosecond field.

Software watches a status word that holds valid, overflow, transmit-flag and port fields. It reads the head stamp and sub-nanosecond values and pulses a next strobe to step to the following entry. If the queue cannot take both entries of a pair, the whole pair is discarded and a sticky overflow flag is raised. The interrupt line stays high for as long as the queue holds an entry.

Top module: `ts_twostep_fifo`

## Requirements
- R1: After reset the queue is empty. Valid, overflow, transmit flag, port, stamp, sub-nanosecond and irq all read 0.
- R2: A push with at most DEPTH-2 entries stored appends two entries. The first has transmit flag 1, the pushed port and stamp, and the pushed sub-nanosecond bits. If it is at the head, it shows on the outputs in the cycle after the push edge.
- R3: The second entry of a pair has transmit flag 0 and the pushed port. head_stamp shifted left by 8, OR'd with head_subns, equals the pushed frame identifier, for every identifier from 0 to 511.
- R4: A next pulse while the queue is not empty removes the head entry, whatever its transmit flag. Entries leave in the order they were stored.
- R5: A push that finds more than DEPTH-2 entries stored stores nothing and sets overflow.
- R6: Overflow stays set until a next pulse arrives while the queue is empty, which clears it. A next pulse on an empty queue changes no contents, and a push in the same cycle is still taken.
- R7: Status bit 0 is valid, bit 1 is overflow, bit 2 is the head transmit flag, and bits 3 and up are the head port. When the queue is empty, valid, transmit flag, port, stamp and sub-nanosecond read 0.
- R8: irq is 1 exactly when the queue holds at least one entry.
- R9: When a push and a next pulse arrive in the same cycle, acceptance depends on the occupancy before the pop. The head is removed and, if accepted, the pair is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| egr_stamp_vld | input | 1 | One-cycle strobe: a two-step frame was stamped |
| egr_port | input | PORT_W | Egress port of the stamped frame |
| egr_ns | input | NS_W | Egress nanosecond timestamp |
| egr_subns | input | 8 | Egress sub-nanosecond bits |
| egr_frame_id | input | 9 | Frame identifier carried from ingress |
| sw_next | input | 1 | Software strobe: pop the head entry |
| status | output | PORT_W+3 | {port, tx flag, overflow, valid} of the head |
| head_stamp | output | NS_W | Stamp field of the head entry |
| head_subns | output | 8 | Sub-nanosecond field of the head entry |
| irq | output | 1 | Level interrupt while the queue is not empty |

## Verification
The bench builds the block with DEPTH set to 8 and keeps the default port and stamp widths. With this depth, four pairs fill the queue, so the exact full and almost-full edges are reached within a few cycles. These are the accept limit at six stored entries and the drop at seven, with and without a concurrent pop. The bench also sweeps all 512 frame identifiers through the second entry of a pair. Long random push and pop traffic repeatedly crosses the full and empty boundaries.

// File: rtl/ts_twostep_pkg.sv
package ts_twostep_pkg;
  localparam int TSF_SUB_W     = 8;
  localparam int TSF_ID_W      = 9;
  localparam int TSF_STAT_VLD  = 0;
  localparam int TSF_STAT_OVF  = 1;
  localparam int TSF_STAT_TX   = 2;
  localparam int TSF_STAT_PORT = 3;

  // upper identifier bits, carried in the stamp field of the second entry
  function automatic logic [31:0] id_upper(input logic [TSF_ID_W-1:0] id);
    return 32'(id >> TSF_SUB_W);
  endfunction

  // low identifier bits, carried in the sub-ns field of the second entry
  function automatic logic [TSF_SUB_W-1:0] id_lower(input logic [TSF_ID_W-1:0] id);
    return id[TSF_SUB_W-1:0];
  endfunction
endpackage

// File: rtl/ts_pair_store.sv
module ts_pair_store #(
  parameter int DEPTH = 64,
  parameter int ENT_W = 46,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [ENT_W-1:0] word_a,
  input  logic [ENT_W-1:0] word_b,
  input  logic [AW-1:0]    rd_idx,
  output logic [ENT_W-1:0] rd_word
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_idx_b;

  assign wr_idx_b = wr_idx + AW'(1);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx]   <= word_a;
      mem[wr_idx_b] <= word_b;
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/ts_fifo_ctrl.sv
module ts_fifo_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_pair,
  input  logic             pop_req,
  output logic             accept,
  output logic             drop,
  output logic             pop_ok,
  output logic [AW-1:0]    wr_idx,
  output logic [AW-1:0]    rd_idx,
  output logic [CNT_W-1:0] occ,
  output logic             ovf
);
  logic fits, empty_pop;
  logic [CNT_W-1:0] occ_d;

  assign fits      = occ <= CNT_W'(DEPTH - 2);
  assign accept    = push_pair & fits;
  assign drop      = push_pair & ~fits;
  assign pop_ok    = pop_req & (occ != '0);
  assign empty_pop = pop_req & (occ == '0);

  always_comb begin
    occ_d = occ;
    if (accept) occ_d = occ_d + CNT_W'(2);
    if (pop_ok) occ_d = occ_d - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ    <= '0;
      wr_idx <= '0;
      rd_idx <= '0;
      ovf    <= 1'b0;
    end else begin
      occ <= occ_d;
      if (accept)         wr_idx <= wr_idx + AW'(2);
      if (pop_ok)         rd_idx <= rd_idx + AW'(1);
      if (drop)           ovf    <= 1'b1;
      else if (empty_pop) ovf    <= 1'b0;
    end
  end
endmodule

// File: rtl/ts_twostep_fifo.sv
module ts_twostep_fifo
  import ts_twostep_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int PORT_W = 7,
  parameter int NS_W   = 30,
  localparam int ENT_W  = 1 + PORT_W + NS_W + TSF_SUB_W,
  localparam int AW     = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int STAT_W = TSF_STAT_PORT + PORT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 egr_stamp_vld,
  input  logic [PORT_W-1:0]    egr_port,
  input  logic [NS_W-1:0]      egr_ns,
  input  logic [TSF_SUB_W-1:0] egr_subns,
  input  logic [TSF_ID_W-1:0]  egr_frame_id,
  input  logic                 sw_next,
  output logic [STAT_W-1:0]    status,
  output logic [NS_W-1:0]      head_stamp,
  output logic [TSF_SUB_W-1:0] head_subns,
  output logic                 irq
);
  // named internal events, also observed by the bound checker
  logic             pair_accept, pair_drop, pop_done, ovf_flag;
  logic [AW-1:0]    wr_idx, rd_idx;
  logic [CNT_W-1:0] occ_cnt;
  logic [ENT_W-1:0] word_ts, word_id, head_word;
  logic             head_vld;

  assign word_ts = {1'b1, egr_port, egr_ns, egr_subns};
  assign word_id = {1'b0, egr_port, NS_W'(id_upper(egr_frame_id)), id_lower(egr_frame_id)};

  ts_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_pair(egr_stamp_vld),
    .pop_req  (sw_next),
    .accept   (pair_accept),
    .drop     (pair_drop),
    .pop_ok   (pop_done),
    .wr_idx   (wr_idx),
    .rd_idx   (rd_idx),
    .occ      (occ_cnt),
    .ovf      (ovf_flag)
  );

  ts_pair_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk    (clk),
    .wr_en  (pair_accept),
    .wr_idx (wr_idx),
    .word_a (word_ts),
    .word_b (word_id),
    .rd_idx (rd_idx),
    .rd_word(head_word)
  );

  assign head_vld = occ_cnt != '0;

  always_comb begin
    status                         = '0;
    status[TSF_STAT_VLD]           = head_vld;
    status[TSF_STAT_OVF]           = ovf_flag;
    status[TSF_STAT_TX]            = head_vld & head_word[ENT_W-1];
    status[TSF_STAT_PORT +: PORT_W] = head_vld ? head_word[ENT_W-2 -: PORT_W] : '0;
    head_stamp = head_vld ? head_word[TSF_SUB_W +: NS_W] : '0;
    head_subns = head_vld ? head_word[TSF_SUB_W-1:0] : '0;
  end

  assign irq = head_vld;
endmodule

// File: rtl/ts_twostep_fifo_chk.sv
module ts_twostep_fifo_chk
  import ts_twostep_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int PORT_W = 7,
  parameter int NS_W   = 30,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int STAT_W = TSF_STAT_PORT + PORT_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sw_next,
  input logic [STAT_W-1:0]    status,
  input logic [NS_W-1:0]      head_stamp,
  input logic [TSF_SUB_W-1:0] head_subns,
  input logic                 irq,
  input logic                 accept,
  input logic                 drop,
  input logic                 pop_ok,
  input logic [CNT_W-1:0]     occ
);
  // R5
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> status[TSF_STAT_OVF]);
  // R5
  drop_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> occ > CNT_W'(DEPTH - 2));
  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[TSF_STAT_OVF] && !(sw_next && !status[TSF_STAT_VLD])) |=> status[TSF_STAT_OVF]);
  // R6
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_next && !status[TSF_STAT_VLD]) |=> !status[TSF_STAT_OVF]);
  // R2
  accept_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pop_ok) |=> occ == $past(occ) + CNT_W'(2));
  // R4
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !accept) |=> occ == $past(occ) - CNT_W'(1));
  // R9
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && accept) |=> occ == $past(occ) + CNT_W'(1));
  // R7
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[TSF_STAT_VLD] |-> (head_stamp == '0 && head_subns == '0 &&
      !status[TSF_STAT_TX] && status[TSF_STAT_PORT +: PORT_W] == '0));
  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (occ != '0));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));
endmodule

bind ts_twostep_fifo ts_twostep_fifo_chk #(.DEPTH(DEPTH), .PORT_W(PORT_W), .NS_W(NS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_next   (sw_next),
  .status    (status),
  .head_stamp(head_stamp),
  .head_subns(head_subns),
  .irq       (irq),
  .accept    (pair_accept),
  .drop      (pair_drop),
  .pop_ok    (pop_done),
  .occ       (occ_cnt)
);

// File: tb/tb_ts_twostep_fifo.sv
`timescale 1ns/1ps
module tb_ts_twostep_fifo;
  localparam int DEPTH = 8;
  localparam int PW = 7;
  localparam int NW = 30;

  typedef struct packed {
    logic          tx;
    logic [PW-1:0] port;
    logic [NW-1:0] ns;
    logic [7:0]    sub;
  } ent_t;

  logic          clk = 0, rst_n = 0;
  logic          egr_stamp_vld = 0, sw_next = 0;
  logic [PW-1:0] egr_port = 0;
  logic [NW-1:0] egr_ns = 0;
  logic [7:0]    egr_subns = 0;
  logic [8:0]    egr_frame_id = 0;
  logic [PW+2:0] status;
  logic [NW-1:0] head_stamp;
  logic [7:0]    head_subns;
  logic          irq;

  int checks = 0, errors = 0, cycles = 0;
  bit model_on = 0;
  ent_t q[$];
  bit   m_ovf = 0;

  always #10 clk = ~clk;

  ts_twostep_fifo #(.DEPTH(DEPTH), .PORT_W(PW), .NS_W(NW)) dut (
    .clk(clk), .rst_n(rst_n), .egr_stamp_vld(egr_stamp_vld), .egr_port(egr_port),
    .egr_ns(egr_ns), .egr_subns(egr_subns), .egr_frame_id(egr_frame_id),
    .sw_next(sw_next), .status(status), .head_stamp(head_stamp),
    .head_subns(head_subns), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: queue of entries, updated on each clock edge
  always @(posedge clk) begin
    int sz;
    ent_t e;
    if (!rst_n) begin
      q.delete();
      m_ovf = 0;
    end else begin
      sz = q.size();
      if (sw_next && sz == 0) m_ovf = 0;
      if (egr_stamp_vld && sz > DEPTH - 2) m_ovf = 1;
      if (sw_next && sz > 0) void'(q.pop_front());
      if (egr_stamp_vld && sz <= DEPTH - 2) begin
        e.tx = 1; e.port = egr_port; e.ns = egr_ns; e.sub = egr_subns;
        q.push_back(e);
        e.tx = 0; e.ns = NW'(egr_frame_id / 256); e.sub = 8'(egr_frame_id % 256);
        q.push_back(e);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk(status[0] == (q.size() != 0), "R7 valid", status[0], q.size() != 0);
      chk(status[1] == m_ovf, "R6 overflow", status[1], m_ovf);
      chk(irq == (q.size() != 0), "R8 irq", irq, q.size() != 0);
      if (q.size() != 0) begin
        chk(status[2] == q[0].tx, "R4 head tx", status[2], q[0].tx);
        chk(status[PW+2:3] == q[0].port, "R4 head port", status[PW+2:3], q[0].port);
        chk(head_stamp == q[0].ns, "R4 head stamp", head_stamp, q[0].ns);
        chk(head_subns == q[0].sub, "R4 head subns", head_subns, q[0].sub);
      end else begin
        chk({status[PW+2:2], head_stamp, head_subns} == '0, "R7 empty fields",
            {status[PW+2:2], head_stamp, head_subns}, 0);
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d cycles", cycles, 100000);
      summary();
      $finish;
    end
  end

  task automatic cyc(input bit p, input bit n, input int pt, input int ns, input int sb, input int id);
    egr_stamp_vld = p; sw_next = n;
    egr_port = PW'(pt); egr_ns = NW'(ns); egr_subns = 8'(sb); egr_frame_id = 9'(id);
    @(posedge clk); #2;
    egr_stamp_vld = 0; sw_next = 0;
  endtask

  task automatic drain(output int n);
    n = 0;
    @(negedge clk);
    while (status[0] && n < 64) begin
      cyc(0, 1, 0, 0, 0, 0);
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(status == '0, "R1 status", status, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(head_stamp == 0 && head_subns == 0, "R1 head", head_stamp, 0);
    model_on = 1;

    // R2 / R3 single pair
    cyc(1, 0, 5, 1234, 17, 300);
    @(negedge clk);
    chk(status[2] == 1, "R2 tx flag", status[2], 1);
    chk(status[PW+2:3] == 5, "R2 port", status[PW+2:3], 5);
    chk(head_stamp == 1234, "R2 stamp", head_stamp, 1234);
    chk(head_subns == 17, "R2 subns", head_subns, 17);
    cyc(0, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk(status[2] == 0, "R3 tx flag", status[2], 0);
    chk(((head_stamp << 8) | NW'(head_subns)) == 300, "R3 id", (head_stamp << 8) | NW'(head_subns), 300);
    cyc(0, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk(status[0] == 0 && irq == 0, "R8 empty irq", irq, 0);

    // R6 pop on empty has no effect
    cyc(0, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk(status[0] == 0, "R6 empty pop", status[0], 0);

    // R5 fill then drop
    for (int i = 0; i < 4; i++) cyc(1, 0, i + 1, 100 + i, i, 10 + i);
    @(negedge clk);
    chk(status[1] == 0, "R5 no ovf at full", status[1], 0);
    cyc(1, 0, 9, 999, 9, 99);
    @(negedge clk);
    chk(status[1] == 1, "R5 ovf on drop", status[1], 1);
    for (int k = 0; k < 8; k++) begin
      if (k % 2 == 0) chk(status[2] == 1 && head_stamp == NW'(100 + k / 2), "R4 order ts", head_stamp, 100 + k / 2);
      else chk(status[2] == 0 && head_subns == 8'(10 + k / 2), "R4 order id", head_subns, 10 + k / 2);
      cyc(0, 1, 0, 0, 0, 0);
      @(negedge clk);
    end
    chk(status[0] == 0, "R5 dropped pair not stored", status[0], 0);
    chk(status[1] == 1, "R6 ovf sticky", status[1], 1);
    cyc(0, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk(status[1] == 0, "R6 ovf cleared", status[1], 0);

    // R9 push+pop at seven stored: dropped
    for (int i = 0; i < 4; i++) cyc(1, 0, 2, 200 + i, 0, i);
    cyc(0, 1, 0, 0, 0, 0);
    cyc(1, 1, 3, 777, 0, 1);
    @(negedge clk);
    chk(status[1] == 1, "R9 drop at seven", status[1], 1);
    drain(n);
    chk(n == 6, "R9 count after drop", n, 6);
    // R6 empty pop with push: clears overflow and stores pair
    cyc(1, 1, 4, 55, 1, 2);
    @(negedge clk);
    chk(status[1] == 0 && status[0] == 1, "R6 clear with push", status, 1);
    drain(n);
    chk(n == 2, "R6 pair kept", n, 2);
    // R9 push+pop at six stored: accepted
    for (int i = 0; i < 3; i++) cyc(1, 0, 2, 300 + i, 0, i);
    cyc(1, 1, 3, 888, 0, 1);
    @(negedge clk);
    chk(status[1] == 0, "R9 accept at six", status[1], 0);
    drain(n);
    chk(n == 7, "R9 count after accept", n, 7);

    // R3 identifier sweep
    for (int id = 0; id < 512; id++) begin
      cyc(1, 0, id % 128, id * 3, id % 251, id);
      cyc(0, 1, 0, 0, 0, 0);
      @(negedge clk);
      chk(status[2] == 0 && ((head_stamp << 8) | NW'(head_subns)) == NW'(id), "R3 id sweep",
          (head_stamp << 8) | NW'(head_subns), id);
      cyc(0, 1, 0, 0, 0, 0);
    end

    // random traffic against the reference
    for (int c = 0; c < 4000; c++)
      cyc($urandom % 2 == 0, $urandom % 3 != 0, $urandom % 128, $urandom, $urandom % 256, $urandom % 512);

    @(negedge clk);
    summary();
    $finish;
  end
endmodule